// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits after a floating-point execution unit and folds the IEEE exception flags of one finished operation into the floating-point status word. Each flag vector comes with a one-cycle valid strobe and a copy of the status word as it stands before the operation. The block decides whether the operation must trap. It then writes the current-exception field, the accrued-exception field and the trap-type field. Finally it signals either a trap request or permission to step the program counter past the instruction.

A trap is taken when a raised flag is also enabled in the status word's enable field. In that case only the enabled flags count, and when several remain a single cause is kept by fixed priority, so the trap handler always sees exactly one reason. A trapping operation leaves the accrued field untouched. A non-trapping one adds its flags to it. The arithmetic that produces the flags, the trap handler and the program counter itself lie outside this block.

Top module: `fpx_status_recorder`

## Requirements
- R1: A synchronous reset drives the status output to all zeros and holds the trap request and PC-advance outputs low.
- R2: A valid operation requests a trap exactly when the bitwise AND of its flag vector with the enable field (status bits 27:23) is non-zero. Flag bit order: invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R3: On a trapping operation the current field (status bits 4:0) holds exactly one bit: the highest-priority bit of flags AND enables. The priority is invalid, then overflow, then underflow, then divide-by-zero, then inexact.
- R4: On a non-trapping operation the current field equals the flag vector unchanged, including flags whose enable bit is clear.
- R5: On a non-trapping operation the accrued field (status bits 9:5) becomes its input value ORed with the flags. On a trapping operation it keeps its input value.
- R6: On a trapping operation the trap-type field (status bits 16:14) is set to 1. On a non-trapping operation it keeps its input value.
- R7: For every valid operation exactly one of trap request and PC advance is asserted, and PC advance is asserted exactly when no trap is requested.
- R8: A valid operation with an all-zero flag vector clears the current field, requests no trap and advances the PC.
- R9: In a cycle without a valid strobe the registered status word holds its value and both trap request and PC advance stay low.
- R10: Status bits outside the current, accrued and trap-type fields are copied from the input word unchanged.
- R11: Results appear one clock after the valid strobe and last for one cycle. The updated status word persists until the next valid operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One-cycle strobe marking a finished operation |
| op_flags | input | 5 | IEEE exception flags of the operation |
| stat_in | input | 32 | Status word before the operation |
| stat_q | output | 32 | Registered updated status word |
| trap_req | output | 1 | Pulse: the operation traps |
| pc_adv | output | 1 | Pulse: step the program counter past the instruction |

## Verification
A wrong trap decision shows at the ports one cycle after the strobe. Both pulses are then wrong together, and the accrued and trap-type fields take the wrong branch. A faulty priority picker shows only when two or more enabled flags are raised at once, so the enable mask and the flag vector are swept through every combination. A stuck or leaking status register shows in the first idle cycle after an operation, where the word must not move and neither pulse may appear.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W  = 5;
  // flag bit order; higher index wins when narrowing
  localparam int FLG_NV  = 4;
  localparam int FLG_OF  = 3;
  localparam int FLG_UF  = 2;
  localparam int FLG_DZ  = 1;
  localparam int FLG_NX  = 0;
  // status word layout
  localparam int CUR_LO  = 0;
  localparam int ACC_LO  = 5;
  localparam int TT_LO   = 14;
  localparam int TT_W    = 3;
  localparam int TEN_LO  = 23;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

  typedef logic [FLAG_W-1:0] flags_t;

  // keep only the highest-indexed set bit
  function automatic flags_t pick_cause(flags_t m);
    flags_t r;
    r = '0;
    for (int i = 0; i < FLAG_W; i++) begin
      if (m[i]) begin
        r = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
  import fpx_pkg::*;
(
  input  flags_t flags,
  input  flags_t enables,
  output logic   trap,
  output flags_t cause
);
  flags_t masked;

  always_comb begin
    masked = flags & enables;
    trap   = |masked;
    cause  = trap ? pick_cause(masked) : flags;
  end
endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] stat_in,
  input  logic              trap,
  input  flags_t            cause,
  output logic [STAT_W-1:0] stat_next
);
  always_comb begin
    stat_next = stat_in;
    stat_next[CUR_LO +: FLAG_W] = cause;
    if (trap) begin
      stat_next[TT_LO +: TT_W] = TT_IEEE;
    end else begin
      stat_next[ACC_LO +: FLAG_W] = stat_in[ACC_LO +: FLAG_W] | cause;
    end
  end
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [4:0]        op_flags,
  input  logic [STAT_W-1:0] stat_in,
  output logic [STAT_W-1:0] stat_q,
  output logic              trap_req,
  output logic              pc_adv
);
  // named internal events
  logic              trap_now;
  flags_t            cause_now;
  logic [STAT_W-1:0] stat_nx;

  fpx_trap_eval u_eval (
    .flags   (op_flags),
    .enables (stat_in[TEN_LO +: FLAG_W]),
    .trap    (trap_now),
    .cause   (cause_now)
  );

  fpx_status_merge #(.STAT_W(STAT_W)) u_merge (
    .stat_in   (stat_in),
    .trap      (trap_now),
    .cause     (cause_now),
    .stat_next (stat_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      trap_req <= 1'b0;
      pc_adv   <= 1'b0;
    end else begin
      trap_req <= op_valid & trap_now;
      pc_adv   <= op_valid & ~trap_now;
      if (op_valid) stat_q <= stat_nx;
    end
  end
endmodule

// File: rtl/fpx_status_recorder_chk.sv
module fpx_status_recorder_chk #(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [4:0]        op_flags,
  input logic [STAT_W-1:0] stat_in,
  input logic [STAT_W-1:0] stat_q,
  input logic              trap_req,
  input logic              pc_adv,
  input logic              trap_now
);
  // R2: registered trap follows the evaluated decision
  assert_trap_decision_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (trap_req == $past(trap_now)));

  // R3: a trap reports exactly one enabled cause
  assert_single_cause_R3: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ($countones(stat_q[4:0]) == 1 &&
                  (stat_q[4:0] & stat_q[27:23]) == stat_q[4:0]));

  // R4: no trap keeps the flag vector as given
  assert_plain_flags_R4: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (trap_req || stat_q[4:0] == $past(op_flags)));

  // R5: accrual only when not trapping
  assert_accrue_R5: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (stat_q[9:5] == (trap_req ? $past(stat_in[9:5])
                                           : ($past(stat_in[9:5]) | $past(op_flags)))));

  // R6: trap type code on traps
  assert_trap_type_R6: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (stat_q[16:14] == 3'd1));

  // R7: exactly one outcome per operation
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (trap_req ^ pc_adv));

  // R9: idle cycle holds state and stays quiet
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(stat_q) && !trap_req && !pc_adv));
endmodule

bind fpx_status_recorder fpx_status_recorder_chk #(.STAT_W(STAT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_flags (op_flags),
  .stat_in  (stat_in),
  .stat_q   (stat_q),
  .trap_req (trap_req),
  .pc_adv   (pc_adv),
  .trap_now (trap_now)
);

// File: tb/test_fpx_status_recorder.sv
`timescale 1ns/1ps
module test_fpx_status_recorder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic [31:0] stat_in = '0;
  logic [31:0] stat_q;
  logic        trap_req;
  logic        pc_adv;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fpx_status_recorder #(.STAT_W(32)) i_fpx_status_recorder (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
    .stat_in(stat_in), .stat_q(stat_q), .trap_req(trap_req), .pc_adv(pc_adv)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // priority written as an explicit chain
  function automatic logic [4:0] narrow(input logic [4:0] m);
    if (m[4])      return 5'b10000;
    else if (m[3]) return 5'b01000;
    else if (m[2]) return 5'b00100;
    else if (m[1]) return 5'b00010;
    else if (m[0]) return 5'b00001;
    return 5'b00000;
  endfunction

  task automatic run_op(input logic [4:0] f, input logic [31:0] w);
    logic [4:0]  en, m, cur, acc;
    logic        tr;
    logic [2:0]  tt;
    logic [31:0] keep_mask;
    en  = w[27:23];
    m   = f & en;
    tr  = (m != 5'd0);
    cur = tr ? narrow(m) : f;
    acc = tr ? w[9:5] : (w[9:5] | f);
    tt  = tr ? 3'd1 : w[16:14];
    keep_mask = ~(32'h1F | (32'h1F << 5) | (32'h7 << 14));
    @(negedge clk);
    op_valid = 1'b1; op_flags = f; stat_in = w;
    @(negedge clk);
    op_valid = 1'b0;
    check("R2 trap", {31'd0, trap_req}, {31'd0, tr});
    check("R7 pc_adv", {31'd0, pc_adv}, {31'd0, ~tr});
    check(tr ? "R3 narrowed cause" : "R4 plain flags", {27'd0, stat_q[4:0]}, {27'd0, cur});
    check("R5 accrued", {27'd0, stat_q[9:5]}, {27'd0, acc});
    check("R6 trap type", {29'd0, stat_q[16:14]}, {29'd0, tt});
    check("R10 other bits", stat_q & keep_mask, w & keep_mask);
    if (f == 5'd0)
      check("R8 no flags", {stat_q[4:0], pc_adv, trap_req}, {5'd0, 1'b1, 1'b0});
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset stat", stat_q, 32'd0);
    check("R1 reset pulses", {30'd0, trap_req, pc_adv}, 32'd0);
    rst = 1'b0;
    // exhaustive sweep of flags against enable mask
    for (int t = 0; t < 32; t++) begin
      for (int f = 0; f < 32; f++) begin
        logic [31:0] w;
        w = 32'((t * 32 + f + 1) * 32'h9E3779B1);
        w[27:23] = t[4:0];
        run_op(f[4:0], w);
      end
    end
    // R11 / R9: word persists, pulses last one cycle, idle input ignored
    run_op(5'b10101, 32'h0F80_0000);
    held = stat_q;
    @(negedge clk);
    stat_in = 32'hFFFF_FFFF; op_flags = 5'h1F;
    check("R11 pulse width", {30'd0, trap_req, pc_adv}, 32'd0);
    @(negedge clk);
    check("R9 idle hold", stat_q, held);
    check("R9 idle quiet", {30'd0, trap_req, pc_adv}, 32'd0);
    // R1 again: reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after use", stat_q, 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule